// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block turns single register commands into the bus accesses that a peripheral with an indirect address/data window needs. The peripheral exposes one bus location that selects a 16-bit internal register (the selector) and another through which that register's value is read or written (the window). A requester issues one command at a time over a request/acknowledge port: plain read, plain write, AND-mask, OR-set, combined mask-then-set, or copy from one register to another. Every read-modify-write and copy is built from one indirect read followed by one indirect write.

On hosts whose bus posts writes, a long stream of writes must be flushed now and then. The sequencer keeps a count of writes issued since the last read. When the `flushEn` input is high and a write would push that count past the limit, it first issues a dummy read of a separate flush location, which may be 16 or 32 bits wide. The count then restarts at 1. The bus side is a simple master. It holds each single access until the slave acknowledges it.

Top module: `ind_reg_seq`

## Requirements
- R1: A read command (op 0) issues a 16-bit bus write of the register number to `CTRL_ADDR`, then a 16-bit bus read of `DATA_ADDR`. `rdData` returns the low 16 bits of that read's data.
- R2: A write command (op 1) issues a 16-bit bus write of the register number to `CTRL_ADDR`, then a 16-bit bus write of `cmdData` to `DATA_ADDR`.
- R3: Every indirect read, including the read half of a read-modify-write or copy, resets the write-run count to 0.
- R4: With `flushEn` high, a write that finds the run count equal to `MAX_RUN` is preceded by one bus read of `FLUSH_ADDR`, and the count becomes 1. Otherwise the write adds 1 to the count, so the count never exceeds `MAX_RUN`.
- R5: With `flushEn` low, writes leave the run count unchanged and no flush read is issued.
- R6: The mask (op 2), set (op 3) and mask-set (op 4) commands read the register and write back read AND `cmdMask`, read OR `cmdData`, and (read AND `cmdMask`) OR `cmdData` respectively. `rdData` returns the value read.
- R7: Copy (op 5) reads register `cmdSrc` and writes that value unchanged to register `cmdReg`. `rdData` returns the copied value.
- R8: `cmdAck` is high for exactly one cycle, the cycle after the bus acknowledge of the command's last access. A command is accepted only while the sequencer is idle, so at most one command is in flight.
- R9: `busReq`, `busAddr`, `busWe`, `busSize` and `busWdata` hold steady until `busAck`. `busSize` is 1 (32-bit) only for the flush read and only when `FLUSH_WIDE` is 1. Every other access is 16-bit (`busSize` 0), with data in the low half.
- R10: After reset, `busReq` and `cmdAck` are low, `rdData` is 0 and the run count is 0.
- R11: The unused op codes 6 and 7 behave exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flushEn | input | 1 | Enables write-run counting and flush reads |
| cmdReq | input | 1 | Command request, held until `cmdAck` |
| cmdOp | input | 3 | Operation code (see R1, R2, R6, R7, R11) |
| cmdReg | input | REG_W | Target register number |
| cmdSrc | input | REG_W | Source register number for copy |
| cmdMask | input | REG_W | AND mask for mask and mask-set |
| cmdData | input | REG_W | Write value or OR value |
| cmdAck | output | 1 | One-cycle completion pulse |
| rdData | output | REG_W | Value read by the command, valid with `cmdAck` |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | 1 for a bus write |
| busSize | output | 1 | 0 for a 16-bit access, 1 for a 32-bit access |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | 2*REG_W | Bus write data |
| busAck | input | 1 | Slave acknowledge of the current access |
| busRdata | input | 2*REG_W | Bus read data, valid with `busAck` |

## Verification
The bench builds the block with `MAX_RUN` set to 4 and `FLUSH_WIDE` set to 1. With a short run limit, the flush boundary, the restart at 1 and the periodic flush after every fourth write can all be reached within a handful of commands. It also becomes cheap to interleave reads and disabled stretches with the counting. With the wide flush, the flush read differs in size from every other access, so a flush sent with the wrong width or to the wrong place shows up at the bus. Slave latency varies from zero to two cycles, which tests that the bus signals are held steady while waiting.

// File: rtl/ind_reg_seq_pkg.sv
package ind_reg_seq_pkg;

  localparam logic [2:0] OP_READ    = 3'd0;
  localparam logic [2:0] OP_WRITE   = 3'd1;
  localparam logic [2:0] OP_MASK    = 3'd2;
  localparam logic [2:0] OP_SET     = 3'd3;
  localparam logic [2:0] OP_MASKSET = 3'd4;
  localparam logic [2:0] OP_COPY    = 3'd5;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_FLUSH,
    ACC_SEL_RD,
    ACC_DATA_RD,
    ACC_SEL_WR,
    ACC_DATA_WR
  } accSel_e;

  typedef struct packed {
    logic    capture;
    logic    loadRead;
    accSel_e acc;
  } seqStrobe_t;

endpackage

// File: rtl/ind_reg_seq_ctrl.sv
module ind_reg_seq_ctrl
  import ind_reg_seq_pkg::*;
#(
  parameter int MAX_RUN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdReq,
  input  logic [2:0] cmdOp,
  input  logic       flushEn,
  input  logic       busAck,
  output seqStrobe_t strobe,
  output logic       busReq,
  output logic       cmdAck
);

  localparam int CNT_W = $clog2(MAX_RUN + 1);
  localparam logic [CNT_W-1:0] RUN_LIMIT = CNT_W'(MAX_RUN);

  typedef enum logic [2:0] {
    S_IDLE, S_FLUSH, S_RSEL, S_RDATA, S_WSEL, S_WDATA, S_RESP
  } state_e;

  state_e state, stateNext;
  logic [CNT_W-1:0] runCnt;
  logic hasWriteQ;

  logic idleTake, takeWrite, enterRead, enterWrite, doFlush;
  state_e writeFirst;

  assign idleTake   = (state == S_IDLE) && cmdReq;
  assign takeWrite  = idleTake && (cmdOp == OP_WRITE);
  assign enterRead  = idleTake && (cmdOp != OP_WRITE);
  assign enterWrite = takeWrite || ((state == S_RDATA) && busAck && hasWriteQ);
  assign doFlush    = enterWrite && flushEn && (runCnt == RUN_LIMIT);
  assign writeFirst = doFlush ? S_FLUSH : S_WSEL;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (idleTake) stateNext = takeWrite ? writeFirst : S_RSEL;
      S_FLUSH: if (busAck) stateNext = S_WSEL;
      S_RSEL:  if (busAck) stateNext = S_RDATA;
      S_RDATA: if (busAck) stateNext = hasWriteQ ? writeFirst : S_RESP;
      S_WSEL:  if (busAck) stateNext = S_WDATA;
      S_WDATA: if (busAck) stateNext = S_RESP;
      S_RESP:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      hasWriteQ <= 1'b0;
      runCnt    <= '0;
    end else begin
      state <= stateNext;
      if (idleTake)
        hasWriteQ <= (cmdOp == OP_MASK) || (cmdOp == OP_SET) ||
                     (cmdOp == OP_MASKSET) || (cmdOp == OP_COPY);
      if (enterRead)
        runCnt <= '0;
      else if (enterWrite && flushEn) begin
        if (doFlush)
          runCnt <= CNT_W'(1);
        else if (runCnt != RUN_LIMIT)
          runCnt <= runCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strobe.capture  = idleTake;
    strobe.loadRead = (state == S_RDATA) && busAck;
    unique case (state)
      S_FLUSH: strobe.acc = ACC_FLUSH;
      S_RSEL:  strobe.acc = ACC_SEL_RD;
      S_RDATA: strobe.acc = ACC_DATA_RD;
      S_WSEL:  strobe.acc = ACC_SEL_WR;
      S_WDATA: strobe.acc = ACC_DATA_WR;
      default: strobe.acc = ACC_NONE;
    endcase
  end

  assign busReq = (state != S_IDLE) && (state != S_RESP);
  assign cmdAck = (state == S_RESP);

  // Run count stays within its limit.
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_LIMIT);

  // A completed flush read leaves the count at one.
  assert_flush_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FLUSH && busAck) |=> (runCnt == CNT_W'(1)));

  // Flush phase only starts when flushing was enabled.
  assert_flush_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == S_FLUSH) |-> $past(flushEn));

  // The selector write of a read always sees a cleared count.
  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RSEL) |-> (runCnt == '0));

  // Completion is a single-cycle pulse.
  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |=> !cmdAck);

  // A pending access is not withdrawn.
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> busReq);

endmodule

// File: rtl/ind_reg_seq_dp.sv
module ind_reg_seq_dp
  import ind_reg_seq_pkg::*;
#(
  parameter int               REG_W      = 16,
  parameter int               ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 12'h3FC,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 12'h3FE,
  parameter logic [ADDR_W-1:0] FLUSH_ADDR = 12'h120,
  parameter bit               FLUSH_WIDE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [2:0]           cmdOp,
  input  logic [REG_W-1:0]     cmdReg,
  input  logic [REG_W-1:0]     cmdSrc,
  input  logic [REG_W-1:0]     cmdMask,
  input  logic [REG_W-1:0]     cmdData,
  input  logic [2*REG_W-1:0]   busRdata,
  input  logic                 busReq,
  input  logic                 busAck,
  output logic [ADDR_W-1:0]    busAddr,
  output logic                 busWe,
  output logic                 busSize,
  output logic [2*REG_W-1:0]   busWdata,
  output logic [REG_W-1:0]     rdData
);

  localparam int BUS_W = 2 * REG_W;
  localparam logic [REG_W-1:0] ALL_ONES = '1;

  logic [REG_W-1:0] dstRegQ, srcRegQ, maskQ, setQ, rdQ, wrVal;
  logic [REG_W-1:0] maskIn, setIn;
  logic             flushSize;
  logic             unusedRdHi;

  generate
    if (FLUSH_WIDE) begin : g_flushWide
      assign flushSize = 1'b1;
    end else begin : g_flushNarrow
      assign flushSize = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (cmdOp)
      OP_WRITE:   begin maskIn = '0;       setIn = cmdData; end
      OP_MASK:    begin maskIn = cmdMask;  setIn = '0;      end
      OP_SET:     begin maskIn = ALL_ONES; setIn = cmdData; end
      OP_MASKSET: begin maskIn = cmdMask;  setIn = cmdData; end
      default:    begin maskIn = ALL_ONES; setIn = '0;      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstRegQ <= '0;
      srcRegQ <= '0;
      maskQ   <= '0;
      setQ    <= '0;
      rdQ     <= '0;
    end else begin
      if (strobe.capture) begin
        dstRegQ <= cmdReg;
        srcRegQ <= (cmdOp == OP_COPY) ? cmdSrc : cmdReg;
        maskQ   <= maskIn;
        setQ    <= setIn;
      end
      if (strobe.loadRead)
        rdQ <= busRdata[REG_W-1:0];
    end
  end

  assign unusedRdHi = ^busRdata[BUS_W-1:REG_W];
  assign wrVal  = (rdQ & maskQ) | setQ;
  assign rdData = rdQ;

  always_comb begin
    busAddr  = '0;
    busWe    = 1'b0;
    busSize  = 1'b0;
    busWdata = '0;
    unique case (strobe.acc)
      ACC_FLUSH: begin
        busAddr = FLUSH_ADDR;
        busSize = flushSize;
      end
      ACC_SEL_RD: begin
        busAddr  = CTRL_ADDR;
        busWe    = 1'b1;
        busWdata = BUS_W'(srcRegQ);
      end
      ACC_DATA_RD: busAddr = DATA_ADDR;
      ACC_SEL_WR: begin
        busAddr  = CTRL_ADDR;
        busWe    = 1'b1;
        busWdata = BUS_W'(dstRegQ);
      end
      ACC_DATA_WR: begin
        busAddr  = DATA_ADDR;
        busWe    = 1'b1;
        busWdata = BUS_W'(wrVal);
      end
      default: ;
    endcase
  end

  // Access fields do not move while the slave has not answered.
  assert_bus_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> ($stable(busAddr) && $stable(busWe) &&
                             $stable(busSize) && $stable(busWdata)));

  // Only the flush location may be accessed at full width.
  assert_narrow_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busSize) |-> (busAddr == FLUSH_ADDR && !busWe));

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq
  import ind_reg_seq_pkg::*;
#(
  parameter int               REG_W      = 16,
  parameter int               ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 12'h3FC,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 12'h3FE,
  parameter logic [ADDR_W-1:0] FLUSH_ADDR = 12'h120,
  parameter bit               FLUSH_WIDE = 1'b0,
  parameter int               MAX_RUN    = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 flushEn,
  input  logic                 cmdReq,
  input  logic [2:0]           cmdOp,
  input  logic [REG_W-1:0]     cmdReg,
  input  logic [REG_W-1:0]     cmdSrc,
  input  logic [REG_W-1:0]     cmdMask,
  input  logic [REG_W-1:0]     cmdData,
  output logic                 cmdAck,
  output logic [REG_W-1:0]     rdData,
  output logic                 busReq,
  output logic                 busWe,
  output logic                 busSize,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [2*REG_W-1:0]   busWdata,
  input  logic                 busAck,
  input  logic [2*REG_W-1:0]   busRdata
);

  seqStrobe_t strobe;

  ind_reg_seq_ctrl #(
    .MAX_RUN(MAX_RUN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdReq  (cmdReq),
    .cmdOp   (cmdOp),
    .flushEn (flushEn),
    .busAck  (busAck),
    .strobe  (strobe),
    .busReq  (busReq),
    .cmdAck  (cmdAck)
  );

  ind_reg_seq_dp #(
    .REG_W      (REG_W),
    .ADDR_W     (ADDR_W),
    .CTRL_ADDR  (CTRL_ADDR),
    .DATA_ADDR  (DATA_ADDR),
    .FLUSH_ADDR (FLUSH_ADDR),
    .FLUSH_WIDE (FLUSH_WIDE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdOp    (cmdOp),
    .cmdReg   (cmdReg),
    .cmdSrc   (cmdSrc),
    .cmdMask  (cmdMask),
    .cmdData  (cmdData),
    .busRdata (busRdata),
    .busReq   (busReq),
    .busAck   (busAck),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busSize  (busSize),
    .busWdata (busWdata),
    .rdData   (rdData)
  );

endmodule

// File: tb/ind_reg_seq_tb.sv
module ind_reg_seq_tb;

  localparam int          MAXR  = 4;
  localparam logic [11:0] CTRLA = 12'h3FC;
  localparam logic [11:0] DATAA = 12'h3FE;
  localparam logic [11:0] FLSHA = 12'h120;

  localparam logic [2:0] O_RD = 3'd0, O_WR = 3'd1, O_MSK = 3'd2,
                         O_SET = 3'd3, O_MS = 3'd4, O_CP = 3'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushEn = 1'b1;
  logic cmdReq = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [15:0] cmdReg = '0, cmdSrc = '0, cmdMask = '0, cmdData = '0;
  logic cmdAck;
  logic [15:0] rdData;
  logic busReq, busWe, busSize;
  logic [11:0] busAddr;
  logic [31:0] busWdata;
  logic busAck = 1'b0;
  logic [31:0] busRdata = '0;

  always #2 clk = ~clk;

  ind_reg_seq #(
    .REG_W(16), .ADDR_W(12), .CTRL_ADDR(CTRLA), .DATA_ADDR(DATAA),
    .FLUSH_ADDR(FLSHA), .FLUSH_WIDE(1'b1), .MAX_RUN(MAXR)
  ) u_dut (
    .clk(clk), .rstN(rstN), .flushEn(flushEn), .cmdReq(cmdReq),
    .cmdOp(cmdOp), .cmdReg(cmdReg), .cmdSrc(cmdSrc), .cmdMask(cmdMask),
    .cmdData(cmdData), .cmdAck(cmdAck), .rdData(rdData), .busReq(busReq),
    .busWe(busWe), .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .busRdata(busRdata)
  );

  typedef struct {
    bit          we;
    bit          size;
    logic [11:0] addr;
    logic [31:0] wdata;
    string       tag;
  } busTxn_t;

  busTxn_t expQ[$];
  logic [15:0] mdlRegs[int];
  logic [15:0] slvRegs[int];
  int mdlCnt = 0;
  int checks = 0;
  int fails = 0;
  logic [15:0] slvSel = '0;
  int waitCnt = 0;
  int lat = 0;
  int txnNum = 0;

  function automatic logic [15:0] initVal(logic [15:0] a);
    return a ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void pushTxn(bit we, bit sz, logic [11:0] a, logic [31:0] d, string tag);
    busTxn_t t;
    t.we = we; t.size = sz; t.addr = a; t.wdata = d; t.tag = tag;
    expQ.push_back(t);
  endfunction

  // Peripheral slave with indirect window, compared against the model queue.
  always @(negedge clk) begin
    if (!rstN) begin
      busAck = 1'b0;
      waitCnt = 0;
    end else if (busAck) begin
      busAck = 1'b0;
    end else if (busReq) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R8", "unexpected bus access addr", {20'd0, busAddr}, 32'd0);
      end else if (waitCnt < lat) begin
        waitCnt++;
      end else begin
        busTxn_t e;
        e = expQ.pop_front();
        chk(busWe === e.we && busAddr === e.addr && busSize === e.size,
            e.tag, "bus access {we,size,addr}",
            {18'd0, busWe, busSize, busAddr}, {18'd0, e.we, e.size, e.addr});
        if (e.we)
          chk(busWdata === e.wdata, e.tag, "bus write data", busWdata, e.wdata);
        busRdata = 32'h0;
        if (busWe && busAddr == CTRLA) slvSel = busWdata[15:0];
        else if (busWe && busAddr == DATAA) slvRegs[int'(slvSel)] = busWdata[15:0];
        else if (!busWe && busAddr == DATAA)
          busRdata = {16'h5A5A, slvRegs.exists(int'(slvSel)) ? slvRegs[int'(slvSel)] : initVal(slvSel)};
        else if (!busWe && busAddr == FLSHA) busRdata = 32'hC0DE_1234;
        busAck = 1'b1;
        waitCnt = 0;
        txnNum++;
        lat = txnNum % 3;
      end
    end
  end

  task automatic runCmd(logic [2:0] op, logic [15:0] r, logic [15:0] s,
                        logic [15:0] m, logic [15:0] d, string tag);
    bit hasRd, hasWr;
    logic [15:0] src, rv, wv;
    hasRd = (op != O_WR);
    hasWr = (op >= O_WR) && (op <= O_CP);
    src = (op == O_CP) ? s : r;
    rv = '0;
    if (hasRd) begin
      mdlCnt = 0;
      pushTxn(1'b1, 1'b0, CTRLA, {16'd0, src}, tag);
      pushTxn(1'b0, 1'b0, DATAA, 32'd0, tag);
      rv = mdlRegs.exists(int'(src)) ? mdlRegs[int'(src)] : initVal(src);
    end
    if (hasWr) begin
      case (op)
        O_WR:    wv = d;
        O_MSK:   wv = rv & m;
        O_SET:   wv = rv | d;
        O_MS:    wv = (rv & m) | d;
        default: wv = rv;
      endcase
      if (flushEn) begin
        if (mdlCnt == MAXR) begin
          pushTxn(1'b0, 1'b1, FLSHA, 32'd0, "R4");
          mdlCnt = 1;
        end else mdlCnt++;
      end
      pushTxn(1'b1, 1'b0, CTRLA, {16'd0, r}, tag);
      pushTxn(1'b1, 1'b0, DATAA, {16'd0, wv}, tag);
      mdlRegs[int'(r)] = wv;
    end
    @(negedge clk);
    cmdReq = 1'b1; cmdOp = op; cmdReg = r; cmdSrc = s; cmdMask = m; cmdData = d;
    @(negedge clk);
    while (!cmdAck) @(negedge clk);
    cmdReq = 1'b0;
    if (hasRd) chk(rdData === rv, tag, "rdData", {16'd0, rdData}, {16'd0, rv});
    chk(expQ.size() == 0, tag, "accesses left at ack", expQ.size(), 0);
    @(negedge clk);
    chk(cmdAck === 1'b0, "R8", "ack longer than one cycle", {31'd0, cmdAck}, 0);
  endtask

  task automatic mainSeq();
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: idle outputs after reset
    chk(busReq === 1'b0, "R10", "busReq after reset", {31'd0, busReq}, 0);
    chk(cmdAck === 1'b0, "R10", "cmdAck after reset", {31'd0, cmdAck}, 0);
    chk(rdData === 16'd0, "R10", "rdData after reset", {16'd0, rdData}, 0);
    // R1 plain read, R2 plain write, read back
    runCmd(O_RD, 16'h0012, 16'h0, 16'h0, 16'h0, "R1");
    runCmd(O_WR, 16'h0012, 16'h0, 16'h0, 16'hBEEF, "R2");
    runCmd(O_RD, 16'h0012, 16'h0, 16'h0, 16'h0, "R1");
    // R4: flush on the fifth write after a read, then every fourth
    for (int i = 0; i < 10; i++)
      runCmd(O_WR, 16'(i + 3), 16'h0, 16'h0, 16'(16'h1000 + i), "R4");
    // R3: a read in mid-run restarts the count
    runCmd(O_RD, 16'h0004, 16'h0, 16'h0, 16'h0, "R3");
    for (int i = 0; i < 6; i++)
      runCmd(O_WR, 16'h0020, 16'h0, 16'h0, 16'(i), "R3");
    // R5: disabled flushing freezes the count
    runCmd(O_RD, 16'h0020, 16'h0, 16'h0, 16'h0, "R5");
    runCmd(O_WR, 16'h0021, 16'h0, 16'h0, 16'h0101, "R5");
    runCmd(O_WR, 16'h0022, 16'h0, 16'h0, 16'h0202, "R5");
    flushEn = 1'b0;
    for (int i = 0; i < 8; i++)
      runCmd(O_WR, 16'h0023, 16'h0, 16'h0, 16'(i), "R5");
    flushEn = 1'b1;
    for (int i = 0; i < 3; i++)
      runCmd(O_WR, 16'h0024, 16'h0, 16'h0, 16'(i), "R5");
    // R6 read-modify-write primitives
    runCmd(O_MSK, 16'h0012, 16'h0, 16'h0FF0, 16'hFFFF, "R6");
    runCmd(O_SET, 16'h0012, 16'h0, 16'h0000, 16'h8001, "R6");
    runCmd(O_MS,  16'h0030, 16'h0, 16'hF00F, 16'h0660, "R6");
    runCmd(O_RD,  16'h0030, 16'h0, 16'h0, 16'h0, "R6");
    // R7 copy
    runCmd(O_CP, 16'h0040, 16'h0012, 16'h0, 16'h0, "R7");
    runCmd(O_RD, 16'h0040, 16'h0, 16'h0, 16'h0, "R7");
    // R11 unused codes act as read
    runCmd(3'd6, 16'h0040, 16'h0, 16'h0, 16'h0, "R11");
    runCmd(3'd7, 16'h0030, 16'h0, 16'h0, 16'h0, "R11");
    // R9 mixed traffic with varying slave latency
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[9:7] == 3'd0) flushEn = ~flushEn;
      runCmd(3'(lfsr[15:13] % 6), {13'd0, lfsr[2:0]}, {13'd0, lfsr[5:3]},
             {lfsr[7:0], lfsr[15:8]}, lfsr, "R9");
    end
  endtask

  initial begin
    fork
      mainSeq();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule